// File: doc/BRIEF.md
# Configurable GPIO Pin Bank with Per-Pin Event Detection

The block is a bank of general-purpose pins. Each pin is set up by one 32-bit configuration word on a simple memory-mapped register bus. A word holds the pin's data bit, a 3-bit mode, a peripheral-function select, pull and input-enable bits, pad electrical bits, a lock bit and a 3-bit event-group select. The mode field does two jobs. It sets the pin's direction, and it picks the trigger type for an input pin. Output mode and the five trigger modes therefore exclude one another on any single pin.

Pin inputs pass through a two-flop synchronizer. Each pin has a small tracking state machine with two states. `TRK_PRIME` means no valid previous sample is held. `TRK_RUN` means edges are compared against the previous sample. The transitions are:
- Reset enters `TRK_PRIME`.
- `TRK_PRIME` moves to `TRK_RUN` after one cycle, unless the mode changes again.
- `TRK_RUN` stays in `TRK_RUN`.
- Either state goes to `TRK_PRIME` on any accepted write that changes the mode.

While in `TRK_PRIME` no edge is reported, so a mode change never produces a false edge. A level mode drives a steady event level and an edge mode drives a one-cycle pulse. The per-pin events are also merged into eight group lines, according to each pin's group select. Pull, drive strength, Schmitt and input-enable bits are stored and read back only. For peripheral routing the block only exports the function select.

Top module: `gpio_bank`

## Requirements
- R1: After reset every word reads 0x0000000E while the pin input is low: mode 7 and all other fields 0. `pin_oe`, `pin_evt` and `grp_evt` are all 0. A reset also clears a lock.
- R2: Pin n's word is at byte address 4*n. A write to an address that is not word aligned, or that names a pin at or beyond NUM_PINS, changes nothing. A read of such an address returns 0.
- R3: Only the defined fields are stored. These are bit 0 (data), [3:1] mode, [6:5] function, [8:7] pull, 9 input enable, [11:10] and [23:22] drive, 15 Schmitt, [18:16] group and 21 lock. All other bits read 0.
- R4: In mode 1 (output), `pin_out` equals the data bit and a read of bit 0 returns the stored data bit. `pin_oe` is 1 only when the mode is 1 and the function field [6:5] is 0.
- R5: In any mode other than 1, a read of bit 0 returns the pin input as synchronized. A change on `pin_in` appears in the read after the second rising clock edge.
- R6: Mode 2 drives `pin_evt` high while the synchronized input is high. Mode 3 drives it high while the synchronized input is low.
- R7: Mode 4 pulses `pin_evt` for one cycle on a rising edge, mode 5 on a falling edge and mode 6 on either edge. The pulse follows the second clock edge after the input change.
- R8: A write that changes the mode puts the pin's tracker in `TRK_PRIME` for one cycle. No edge is reported in that cycle, even when the synchronized level differs from the previous sample.
- R9: Modes 0, 1 and 7 never raise `pin_evt`.
- R10: While the lock bit (21) is set, a write changes only the data bit 0 of that word.
- R11: `grp_evt[g]` is the OR of `pin_evt` over all pins whose group field [18:16] equals g.
- R12: `pin_func` carries field [6:5] of each pin's word, as two bits per pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address, used for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Raw pin levels from the pads |
| pin_out | output | NUM_PINS | Output level for each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin |
| pin_func | output | 2*NUM_PINS | Function select for each pin |
| pin_evt | output | NUM_PINS | Event level or pulse for each pin |
| grp_evt | output | 8 | Event lines merged by group |

## Verification
The bench attacks the one-cycle prime window. It raises a pin so that the synchronized level flips exactly on the clock edge that writes an edge mode. A design that keeps the stale previous sample would then report a false rising pulse. It times edge pulses to the cycle after the two-flop synchronizer, so a missing or extra stage shows as a pulse one cycle early or late. It also catches a pulse that lasts longer than one cycle. The bench also writes all ones to a locked word, to a misaligned address and past the last pin. A design with a leaky lock or a sloppy decode would corrupt a neighbouring or locked word. Finally, it checks that the function select alone withdraws output enable and that group moves redirect the merged line.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int CFG_W      = 32;
    localparam int DATA_BIT   = 0;
    localparam int MODE_LSB   = 1;
    localparam int MODE_W     = 3;
    localparam int FUNC_LSB   = 5;
    localparam int FUNC_W     = 2;
    localparam int GRP_LSB    = 16;
    localparam int GRP_W      = 3;
    localparam int LOCK_BIT   = 21;
    localparam int NUM_GROUPS = 1 << GRP_W;

    // defined field bits: data, mode, func, pull, ien, drive0, schmitt, group, lock, drive1
    localparam logic [CFG_W-1:0] CFG_MASK  = 32'h00E7_8FEF;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_000E;

    typedef enum logic [MODE_W-1:0] {
        MD_RSVD   = 3'd0,
        MD_OUT    = 3'd1,
        MD_LVL_HI = 3'd2,
        MD_LVL_LO = 3'd3,
        MD_RISE   = 3'd4,
        MD_FALL   = 3'd5,
        MD_BOTH   = 3'd6,
        MD_OFF    = 3'd7
    } pin_mode_e;

    typedef enum logic {
        TRK_PRIME = 1'b0,
        TRK_RUN   = 1'b1
    } trk_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              sync_in,
    output logic [CFG_W-1:0]  rd_word,
    output logic              pad_out,
    output logic              pad_oe,
    output logic [FUNC_W-1:0] func_sel,
    output logic [GRP_W-1:0]  grp_sel,
    output logic              evt
);

    logic [CFG_W-1:0] cfg_q;
    logic             prev_q;
    trk_state_e       state_q;
    trk_state_e       state_d;
    pin_mode_e        mode;
    logic             locked;
    logic             mode_change;

    assign mode        = pin_mode_e'(cfg_q[MODE_LSB +: MODE_W]);
    assign locked      = cfg_q[LOCK_BIT];
    assign mode_change = wr_en && !locked &&
                         (wdata[MODE_LSB +: MODE_W] != cfg_q[MODE_LSB +: MODE_W]);

    // configuration word, lock keeps all but the data bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            if (locked) begin
                cfg_q[DATA_BIT] <= wdata[DATA_BIT];
            end else begin
                cfg_q <= wdata & CFG_MASK;
            end
        end
    end

    // previous synchronized sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
        end
    end

    // tracker state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // tracker next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_PRIME: state_d = mode_change ? TRK_PRIME : TRK_RUN;
            TRK_RUN:   state_d = mode_change ? TRK_PRIME : TRK_RUN;
            default:   state_d = TRK_PRIME;
        endcase
    end

    // outputs
    always_comb begin
        logic run;
        run      = (state_q == TRK_RUN);
        pad_out  = cfg_q[DATA_BIT];
        pad_oe   = 1'b0;
        func_sel = cfg_q[FUNC_LSB +: FUNC_W];
        grp_sel  = cfg_q[GRP_LSB +: GRP_W];
        rd_word  = {cfg_q[CFG_W-1:1], sync_in};
        evt      = 1'b0;
        unique case (mode)
            MD_OUT: begin
                pad_oe  = (cfg_q[FUNC_LSB +: FUNC_W] == '0);
                rd_word = cfg_q;
            end
            MD_LVL_HI: evt = sync_in;
            MD_LVL_LO: evt = !sync_in;
            MD_RISE:   evt = run && sync_in && !prev_q;
            MD_FALL:   evt = run && !sync_in && prev_q;
            MD_BOTH:   evt = run && (sync_in != prev_q);
            MD_RSVD, MD_OFF: evt = 1'b0;
            default:   evt = 1'b0;
        endcase
    end

    // R7: a rising-only pulse never lasts two cycles
    p_rise_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RISE && evt) |=> (mode != MD_RISE || !evt));

    // R7: a falling-only pulse never lasts two cycles
    p_fall_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_FALL && evt) |=> (mode != MD_FALL || !evt));

    // R10: a locked word keeps everything but the data bit
    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_q[CFG_W-1:1]));

    // R9: idle and output modes stay quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF || mode == MD_OUT || mode == MD_RSVD) |-> !evt);

endmodule

// File: rtl/gpio_group_merge.sv
module gpio_group_merge
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       evt,
    input  logic [NUM_PINS*GRP_W-1:0] grp_sel,
    output logic [NUM_GROUPS-1:0]     grp_evt
);

    always_comb begin
        grp_evt = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (grp_sel[p*GRP_W +: GRP_W] == GRP_W'(g)) begin
                    grp_evt[g] = grp_evt[g] | evt[p];
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        // R11: every pin event reaches its selected group line
        p_grp_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
            evt[p] |-> grp_evt[grp_sel[p*GRP_W +: GRP_W]]);
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic [NUM_PINS-1:0]     pin_oe,
    output logic [2*NUM_PINS-1:0]   pin_func,
    output logic [NUM_PINS-1:0]     pin_evt,
    output logic [NUM_GROUPS-1:0]   grp_evt
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]          word_idx;
    logic                      aligned;
    logic [NUM_PINS-1:0]       sync_lvl;
    logic [NUM_PINS-1:0]       wr_sel;
    logic [CFG_W-1:0]          rd_word [NUM_PINS];
    logic [NUM_PINS*GRP_W-1:0] grp_flat;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (sync_lvl)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign wr_sel[i] = bus_we && aligned && (word_idx == IDX_W'(i));

        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel[i]),
            .wdata    (bus_wdata),
            .sync_in  (sync_lvl[i]),
            .rd_word  (rd_word[i]),
            .pad_out  (pin_out[i]),
            .pad_oe   (pin_oe[i]),
            .func_sel (pin_func[i*FUNC_W +: FUNC_W]),
            .grp_sel  (grp_flat[i*GRP_W +: GRP_W]),
            .evt      (pin_evt[i])
        );

        // R9: a driven pin never reports an event
        p_out_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] |-> !pin_evt[i]);
    end

    // read mux, unmatched addresses return zero
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (aligned && word_idx == IDX_W'(i)) begin
                bus_rdata = rd_word[i];
            end
        end
    end

    gpio_group_merge #(.NUM_PINS(NUM_PINS)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (pin_evt),
        .grp_sel (grp_flat),
        .grp_evt (grp_evt)
    );

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    localparam int NP = 8;
    localparam int AW = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [2*NP-1:0] pin_func;
    logic [NP-1:0]   pin_evt;
    logic [7:0]      grp_evt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func),
        .pin_evt(pin_evt), .grp_evt(grp_evt)
    );

    // stimulus table: write then read back the same address
    localparam logic [AW-1:0] V_ADDR [8] = '{11'h01C, 11'h01C, 11'h01C, 11'h004,
                                            11'h020, 11'h7FC, 11'h00A, 11'h008};
    localparam logic [31:0] V_WD [8] = '{32'h0020_0003, 32'h0000_0000, 32'hFFFF_FFFF,
                                        32'hFFDF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF,
                                        32'h0000_0003, 32'h0000_0003};
    localparam logic [31:0] V_EXP [8] = '{32'h0020_0003, 32'h0020_0002, 32'h0020_0003,
                                         32'h00C7_8FEE, 32'h0000_0000, 32'h0000_0000,
                                         32'h0000_0000, 32'h0000_0003};
    localparam string V_TAG [8] = '{"R10", "R10", "R10", "R3", "R2", "R2", "R2", "R4"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends at a negative edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int i = 0; i < NP; i++) begin
            rd(AW'(4*i), r);
            chk("R1 reset word", r, 32'h0000_000E);
        end
        chk("R1 oe", 32'(pin_oe), 32'h0);
        chk("R1 evt", 32'(pin_evt), 32'h0);
        chk("R1 grp", 32'(grp_evt), 32'h0);

        // table walk
        for (int i = 0; i < 8; i++) begin
            wr(V_ADDR[i], V_WD[i]);
            rd(V_ADDR[i], r);
            chk(V_TAG[i], r, V_EXP[i]);
        end

        // R2: misaligned write left pin 3 alone
        wr(11'h00E, 32'h0000_0003);
        rd(11'h00C, r);
        chk("R2 misaligned", r, 32'h0000_000E);

        // R4: output mode drives pin 2
        chk("R4 out", 32'(pin_out[2]), 32'h1);
        chk("R4 oe", 32'(pin_oe[2]), 32'h1);
        chk("R10 locked pin7 oe", 32'(pin_oe[7]), 32'h1);
        // R12 and R4: function select withdraws output enable
        wr(11'h008, 32'h0000_0023);
        chk("R4 oe off with func", 32'(pin_oe[2]), 32'h0);
        chk("R12 func", 32'(pin_func[5:4]), 32'h1);

        // R5: synchronized readback of pin 3
        pin_in[3] = 1'b1;
        step();
        rd(11'h00C, r);
        chk("R5 one edge", r, 32'h0000_000E);
        step();
        rd(11'h00C, r);
        chk("R5 two edges", r, 32'h0000_000F);

        // R6 / R11: level high on pin 3, group 0 then 2
        wr(11'h00C, 32'h0000_0004);
        chk("R6 level high", 32'(pin_evt[3]), 32'h1);
        chk("R11 group0", 32'(grp_evt), 32'h01);
        wr(11'h00C, 32'h0002_0004);
        chk("R11 group2", 32'(grp_evt), 32'h04);
        // R6: level low
        wr(11'h00C, 32'h0000_0006);
        chk("R6 low idle", 32'(pin_evt[3]), 32'h0);
        pin_in[3] = 1'b0;
        step();
        chk("R6 low early", 32'(pin_evt[3]), 32'h0);
        step();
        chk("R6 low active", 32'(pin_evt[3]), 32'h1);

        // R7: rising edge on pin 4
        wr(11'h010, 32'h0000_0008);
        step(); step();
        pin_in[4] = 1'b1;
        step();
        chk("R7 rise early", 32'(pin_evt[4]), 32'h0);
        step();
        chk("R7 rise pulse", 32'(pin_evt[4]), 32'h1);
        step();
        chk("R7 rise end", 32'(pin_evt[4]), 32'h0);
        pin_in[4] = 1'b0;
        step(); step();
        chk("R7 rise ignores fall", 32'(pin_evt[4]), 32'h0);
        // falling
        wr(11'h010, 32'h0000_000A);
        step(); step();
        pin_in[4] = 1'b1;
        step(); step();
        chk("R7 fall ignores rise", 32'(pin_evt[4]), 32'h0);
        step(); step();
        pin_in[4] = 1'b0;
        step(); step();
        chk("R7 fall pulse", 32'(pin_evt[4]), 32'h1);
        step();
        chk("R7 fall end", 32'(pin_evt[4]), 32'h0);
        // either edge
        wr(11'h010, 32'h0000_000C);
        step(); step();
        pin_in[4] = 1'b1;
        step(); step();
        chk("R7 both rise", 32'(pin_evt[4]), 32'h1);
        step();
        pin_in[4] = 1'b0;
        step(); step();
        chk("R7 both fall", 32'(pin_evt[4]), 32'h1);

        // R8: synchronized level flips on the mode-write edge
        pin_in[5] = 1'b1;
        step();
        wr(11'h014, 32'h0000_0008);
        chk("R8 prime no edge", 32'(pin_evt[5]), 32'h0);
        step();
        chk("R8 after prime", 32'(pin_evt[5]), 32'h0);

        // R9: output and off modes stay quiet
        wr(11'h018, 32'h0000_0003);
        pin_in[6] = 1'b1;
        step(); step();
        chk("R9 out mode", 32'(pin_evt[6]), 32'h0);
        wr(11'h018, 32'h0000_000E);
        pin_in[6] = 1'b0;
        step(); step();
        chk("R9 off mode", 32'(pin_evt[6]), 32'h0);

        // R1 / R10: reset clears the lock on pin 7
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        rd(11'h01C, r);
        chk("R1 lock cleared", r, 32'h0000_000E);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule